// File: doc/BRIEF.md
# Transmit Transport Overhead Insertion Port

This block lets an external device supply the transport overhead for an outgoing STS-48 frame, four bits at a time. It generates the port clock as a divided copy of the core clock, one core cycle per half period. It also drives a frame pulse and a read enable that tell the external device when to present each overhead nibble. Both strobes run ahead of the nibble sampling by a lead time of 0 to 7 port periods, set by a static configuration input. The block gathers each pair of nibbles into an octet and hands it to the transmit frame builder. The octet goes out as a one-cycle strobe with its row, overhead column and STS index, and with a flag that says whether the octet should replace the internally generated one.

An insert enable is sampled together with the high nibble of each octet, so insertion is chosen octet by octet. The enable presented with the low nibble plays no part. The section and line overhead processors can still claim any octet through a priority input, which is sampled with the low nibble and clears the insert flag.

Top module: `toh_insert_port`

## Requirements
- R1: While rst_n is low, toh_clk, toh_fp, toh_ren and oct_valid are all 0.
- R2: toh_clk inverts on every core clock edge out of reset and first rises on the first edge. toh_fp and toh_ren change only on the core edge at which toh_clk falls. Nibble, enable and priority inputs are sampled on the core edge at which toh_clk rises.
- R3: A frame is ROWS x ROW_SLOTS port periods. toh_fp is high for exactly the first port period of each frame, and the first period after reset starts a frame.
- R4: toh_ren is high in the first 2 x OH_COLS x N_STS port periods of every row and low in the rest, so it is also high whenever toh_fp is high.
- R5: The nibble for the slot that toh_ren marks in port period m is sampled at the toh_clk rise of period m + cfg_lead. cfg_lead ranges from 0 to 7 and is held constant while out of reset.
- R6: Overhead octets arrive in insertion order, high nibble first, with toh_nib[3] as the most significant bit. Each completed octet raises oct_valid for one core cycle, right after the rise that samples its low nibble, with oct_data = {high, low}.
- R7: oct_ins equals toh_en as sampled with the high nibble. The value of toh_en sampled with the low nibble is ignored.
- R8: If ovr_req is 1 when the low nibble is sampled, oct_ins is 0.
- R9: Octet k of a row (counted from 0) is tagged with oct_col = k / N_STS and oct_sts = k mod N_STS. oct_row gives the row within the frame, counted from 0.
- R10: Nibbles sampled outside the overhead slots are ignored, and no octet is delivered for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lead | input | LEAD_W | Lead of strobes over nibble sampling, in port periods |
| toh_nib | input | 4 | Overhead nibble from the external device |
| toh_en | input | 1 | Insert enable, taken with the high nibble |
| ovr_req | input | 1 | Priority claim by the section or line processor |
| toh_clk | output | 1 | Port clock |
| toh_fp | output | 1 | Frame pulse |
| toh_ren | output | 1 | Read enable |
| oct_valid | output | 1 | Octet strobe to the frame builder |
| oct_data | output | 8 | Assembled octet |
| oct_ins | output | 1 | Octet replaces the generated one |
| oct_row | output | clog2(ROWS+1) | Row of the octet |
| oct_col | output | clog2(OH_COLS+1) | Overhead column of the octet |
| oct_sts | output | clog2(N_STS+1) | STS index of the octet |

## Verification
The nibble value seen at each rising port edge is a function of the sampling instant that is never the same for two neighbouring slots. A swapped nibble order, a sampling slot off by one, or a slip across row and frame boundaries therefore shows up as wrong octet data. Three insert enable patterns are used: always on, alternating in pairs, and two in three. These separate the enable taken with the high nibble from the one presented with the low nibble. A priority pattern that repeats every seven slots lands on both high and low nibbles, which checks that only the low-nibble sample has an effect. Leads of 0, 3, 5 and 7 are each run over more than one frame, which separates the timing of the strobes from the timing of the data.

// File: rtl/toh_pkg.sv
package toh_pkg;
    typedef enum logic {
        NIB_HIGH = 1'b0,
        NIB_LOW  = 1'b1
    } nib_phase_e;
endpackage

// File: rtl/toh_port_timer.sv
module toh_port_timer #(
    parameter int ROWS      = 9,
    parameter int ROW_SLOTS = 540,
    parameter int OH_NIB    = 288,
    parameter int LEAD_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAD_W-1:0] cfg_lead,
    output logic              port_clk,
    output logic              fall_stb,
    output logic              rise_stb,
    output logic              frame_pulse,
    output logic              read_en,
    output logic              data_start
);
    localparam int RW = $clog2(ROWS + 1);
    localparam int SW = $clog2(ROW_SLOTS);
    localparam logic [RW-1:0] LAST_ROW  = RW'(ROWS - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(ROW_SLOTS - 1);
    localparam logic [SW-1:0] OH_END    = SW'(OH_NIB);

    typedef struct packed {
        logic              ph;
        logic [RW-1:0]     row;
        logic [SW-1:0]     slot;
        logic              fp;
        logic              ren;
        logic [LEAD_W-1:0] lead;
        logic              started;
    } tim_t;

    tim_t tim_q, tim_d;
    logic start_d;

    always_comb begin
        tim_d   = tim_q;
        start_d = 1'b0;
        tim_d.ph = ~tim_q.ph;
        if (tim_q.ph) begin
            if (tim_q.slot == LAST_SLOT) begin
                tim_d.slot = '0;
                tim_d.row  = (tim_q.row == LAST_ROW) ? '0 : tim_q.row + 1'b1;
            end else begin
                tim_d.slot = tim_q.slot + 1'b1;
            end
            tim_d.fp  = (tim_d.row == '0) && (tim_d.slot == '0);
            tim_d.ren = (tim_d.slot < OH_END);
            if (!tim_q.started) begin
                if (tim_q.lead == cfg_lead) begin
                    tim_d.started = 1'b1;
                    start_d       = 1'b1;
                end else begin
                    tim_d.lead = tim_q.lead + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q.ph      <= 1'b0;
            tim_q.row     <= LAST_ROW;
            tim_q.slot    <= LAST_SLOT;
            tim_q.fp      <= 1'b0;
            tim_q.ren     <= 1'b0;
            tim_q.lead    <= '0;
            tim_q.started <= 1'b0;
        end else begin
            tim_q <= tim_d;
        end
    end

    assign port_clk    = tim_q.ph;
    assign fall_stb    = tim_q.ph;
    assign rise_stb    = ~tim_q.ph;
    assign frame_pulse = tim_q.fp;
    assign read_en     = tim_q.ren;
    assign data_start  = start_d;
endmodule

// File: rtl/toh_slot_tracker.sv
module toh_slot_tracker
    import toh_pkg::*;
#(
    parameter int N_STS     = 48,
    parameter int ROWS      = 9,
    parameter int ROW_SLOTS = 540,
    parameter int OH_COLS   = 3,
    parameter int OH_NIB    = 288
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fall_stb,
    input  logic                               data_start,
    output logic                               in_oh,
    output nib_phase_e                         phase,
    output logic [$clog2(ROWS+1)-1:0]          row,
    output logic [$clog2(OH_COLS+1)-1:0]       col,
    output logic [$clog2(N_STS+1)-1:0]         sts
);
    localparam int RW = $clog2(ROWS + 1);
    localparam int SW = $clog2(ROW_SLOTS);
    localparam int CW = $clog2(OH_COLS + 1);
    localparam int TW = $clog2(N_STS + 1);
    localparam logic [RW-1:0] LAST_ROW  = RW'(ROWS - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(ROW_SLOTS - 1);
    localparam logic [SW-1:0] OH_END    = SW'(OH_NIB);
    localparam logic [TW-1:0] LAST_STS  = TW'(N_STS - 1);

    typedef struct packed {
        logic          run;
        logic [RW-1:0] row;
        logic [SW-1:0] slot;
        logic [CW-1:0] col;
        logic [TW-1:0] sts;
        nib_phase_e    ph;
    } trk_t;

    trk_t trk_q, trk_d;

    always_comb begin
        trk_d = trk_q;
        if (fall_stb) begin
            if (data_start) begin
                trk_d.run  = 1'b1;
                trk_d.row  = '0;
                trk_d.slot = '0;
                trk_d.col  = '0;
                trk_d.sts  = '0;
                trk_d.ph   = NIB_HIGH;
            end else if (trk_q.run) begin
                if (trk_q.slot == LAST_SLOT) begin
                    trk_d.slot = '0;
                    trk_d.row  = (trk_q.row == LAST_ROW) ? '0 : trk_q.row + 1'b1;
                    trk_d.col  = '0;
                    trk_d.sts  = '0;
                    trk_d.ph   = NIB_HIGH;
                end else begin
                    trk_d.slot = trk_q.slot + 1'b1;
                    if (trk_q.slot < OH_END) begin
                        if (trk_q.ph == NIB_LOW) begin
                            trk_d.ph = NIB_HIGH;
                            if (trk_q.sts == LAST_STS) begin
                                trk_d.sts = '0;
                                trk_d.col = trk_q.col + CW'(1);
                            end else begin
                                trk_d.sts = trk_q.sts + TW'(1);
                            end
                        end else begin
                            trk_d.ph = NIB_LOW;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.run  <= 1'b0;
            trk_q.row  <= '0;
            trk_q.slot <= '0;
            trk_q.col  <= '0;
            trk_q.sts  <= '0;
            trk_q.ph   <= NIB_HIGH;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign in_oh = trk_q.run && (trk_q.slot < OH_END);
    assign phase = trk_q.ph;
    assign row   = trk_q.row;
    assign col   = trk_q.col;
    assign sts   = trk_q.sts;
endmodule

// File: rtl/toh_octet_builder.sv
module toh_octet_builder
    import toh_pkg::*;
#(
    parameter int RW = 4,
    parameter int CW = 2,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_stb,
    input  logic          in_oh,
    input  nib_phase_e    phase,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    input  logic [TW-1:0] sts,
    input  logic [3:0]    nib,
    input  logic          ins_en,
    input  logic          ovr,
    output logic          oct_valid,
    output logic [7:0]    oct_data,
    output logic          oct_ins,
    output logic [RW-1:0] oct_row,
    output logic [CW-1:0] oct_col,
    output logic [TW-1:0] oct_sts
);
    typedef struct packed {
        logic [3:0]    hi;
        logic          en_hi;
        logic          valid;
        logic [7:0]    data;
        logic          ins;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic [TW-1:0] sts;
    } bld_t;

    bld_t bld_q, bld_d;

    always_comb begin
        bld_d       = bld_q;
        bld_d.valid = 1'b0;
        if (rise_stb && in_oh) begin
            if (phase == NIB_HIGH) begin
                bld_d.hi    = nib;
                bld_d.en_hi = ins_en;
            end else begin
                bld_d.valid = 1'b1;
                bld_d.data  = {bld_q.hi, nib};
                bld_d.ins   = bld_q.en_hi & ~ovr;
                bld_d.row   = row;
                bld_d.col   = col;
                bld_d.sts   = sts;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bld_q <= '0;
        end else begin
            bld_q <= bld_d;
        end
    end

    assign oct_valid = bld_q.valid;
    assign oct_data  = bld_q.data;
    assign oct_ins   = bld_q.ins;
    assign oct_row   = bld_q.row;
    assign oct_col   = bld_q.col;
    assign oct_sts   = bld_q.sts;
endmodule

// File: rtl/toh_insert_port.sv
module toh_insert_port
    import toh_pkg::*;
#(
    parameter int N_STS     = 48,
    parameter int ROWS      = 9,
    parameter int ROW_SLOTS = 540,
    parameter int OH_COLS   = 3,
    parameter int LEAD_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LEAD_W-1:0]                 cfg_lead,
    input  logic [3:0]                        toh_nib,
    input  logic                              toh_en,
    input  logic                              ovr_req,
    output logic                              toh_clk,
    output logic                              toh_fp,
    output logic                              toh_ren,
    output logic                              oct_valid,
    output logic [7:0]                        oct_data,
    output logic                              oct_ins,
    output logic [$clog2(ROWS+1)-1:0]         oct_row,
    output logic [$clog2(OH_COLS+1)-1:0]      oct_col,
    output logic [$clog2(N_STS+1)-1:0]        oct_sts
);
    localparam int OH_NIB = 2 * OH_COLS * N_STS;
    localparam int RW     = $clog2(ROWS + 1);
    localparam int CW     = $clog2(OH_COLS + 1);
    localparam int TW     = $clog2(N_STS + 1);

    logic          fall_stb, rise_stb, data_start, in_oh;
    nib_phase_e    phase;
    logic [RW-1:0] trk_row;
    logic [CW-1:0] trk_col;
    logic [TW-1:0] trk_sts;

    toh_port_timer #(
        .ROWS(ROWS), .ROW_SLOTS(ROW_SLOTS), .OH_NIB(OH_NIB), .LEAD_W(LEAD_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead),
        .port_clk(toh_clk), .fall_stb(fall_stb), .rise_stb(rise_stb),
        .frame_pulse(toh_fp), .read_en(toh_ren), .data_start(data_start)
    );

    toh_slot_tracker #(
        .N_STS(N_STS), .ROWS(ROWS), .ROW_SLOTS(ROW_SLOTS),
        .OH_COLS(OH_COLS), .OH_NIB(OH_NIB)
    ) u_tracker (
        .clk(clk), .rst_n(rst_n), .fall_stb(fall_stb), .data_start(data_start),
        .in_oh(in_oh), .phase(phase), .row(trk_row), .col(trk_col), .sts(trk_sts)
    );

    toh_octet_builder #(
        .RW(RW), .CW(CW), .TW(TW)
    ) u_builder (
        .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .in_oh(in_oh),
        .phase(phase), .row(trk_row), .col(trk_col), .sts(trk_sts),
        .nib(toh_nib), .ins_en(toh_en), .ovr(ovr_req),
        .oct_valid(oct_valid), .oct_data(oct_data), .oct_ins(oct_ins),
        .oct_row(oct_row), .oct_col(oct_col), .oct_sts(oct_sts)
    );
endmodule

// File: rtl/toh_insert_port_chk.sv
module toh_insert_port_chk #(
    parameter int N_STS   = 48,
    parameter int ROWS    = 9,
    parameter int OH_COLS = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         toh_clk,
    input logic                         toh_fp,
    input logic                         toh_ren,
    input logic                         oct_valid,
    input logic                         oct_ins,
    input logic                         ovr_req,
    input logic [$clog2(ROWS+1)-1:0]    oct_row,
    input logic [$clog2(OH_COLS+1)-1:0] oct_col,
    input logic [$clog2(N_STS+1)-1:0]   oct_sts
);
    AST_FP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (toh_fp != $past(toh_fp)) |-> (!toh_clk && $past(toh_clk))); // R2
    AST_REN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (toh_ren != $past(toh_ren)) |-> (!toh_clk && $past(toh_clk))); // R2
    AST_FP_WITH_REN: assert property (@(posedge clk) disable iff (!rst_n)
        toh_fp |-> toh_ren); // R4
    AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        oct_valid |-> (toh_clk && !$past(toh_clk))); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        oct_valid |=> !oct_valid); // R6
    AST_OVR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_valid && $past(ovr_req)) |-> !oct_ins); // R8
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        oct_valid |-> (int'(oct_row) < ROWS && int'(oct_col) < OH_COLS
                       && int'(oct_sts) < N_STS)); // R9
endmodule

bind toh_insert_port toh_insert_port_chk #(
    .N_STS(N_STS), .ROWS(ROWS), .OH_COLS(OH_COLS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .toh_clk(toh_clk), .toh_fp(toh_fp),
    .toh_ren(toh_ren), .oct_valid(oct_valid), .oct_ins(oct_ins),
    .ovr_req(ovr_req), .oct_row(oct_row), .oct_col(oct_col), .oct_sts(oct_sts)
);

// File: tb/toh_insert_port_test.sv
`timescale 1ns/1ps
module toh_insert_port_test;
    localparam int NS = 2, NR = 3, RS = 16, OC = 3, LW = 3;
    localparam int OH = 2 * OC * NS;
    localparam int FRAME = NR * RS;
    localparam int RW = $clog2(NR + 1), CW = $clog2(OC + 1), TW = $clog2(NS + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [LW-1:0] cfg_lead = '0;
    logic [3:0]    toh_nib = '0;
    logic          toh_en = 1'b0, ovr_req = 1'b0;
    logic          toh_clk, toh_fp, toh_ren, oct_valid, oct_ins;
    logic [7:0]    oct_data;
    logic [RW-1:0] oct_row;
    logic [CW-1:0] oct_col;
    logic [TW-1:0] oct_sts;

    toh_insert_port #(.N_STS(NS), .ROWS(NR), .ROW_SLOTS(RS), .OH_COLS(OC), .LEAD_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .toh_nib(toh_nib),
        .toh_en(toh_en), .ovr_req(ovr_req), .toh_clk(toh_clk), .toh_fp(toh_fp),
        .toh_ren(toh_ren), .oct_valid(oct_valid), .oct_data(oct_data),
        .oct_ins(oct_ins), .oct_row(oct_row), .oct_col(oct_col), .oct_sts(oct_sts)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nib_at(int f, int seed);
        return (f * 5 + seed + f / 7) & 15;
    endfunction

    function automatic int en_at(int f, int mode);
        if (mode == 0) return 1;
        if (mode == 1) return ((f * 3 + 1) % 4 < 2) ? 1 : 0;
        return (f % 3 != 0) ? 1 : 0;
    endfunction

    function automatic int ovr_at(int f, int mode);
        return (mode != 0 && f % 7 == 3) ? 1 : 0;
    endfunction

    // inputs presented ahead of core edge e_next
    task automatic drive(int e_next, int seed, int mode);
        int f;
        f = (e_next >= 3 && e_next % 2 == 1) ? (e_next - 3) / 2 : e_next + 1000;
        toh_nib = 4'(nib_at(f, seed));
        toh_en  = 1'(en_at(f, mode));
        ovr_req = 1'(ovr_at(f, mode));
    endtask

    task automatic check_cycle(int e, int lead, int seed, int mode);
        int efp, eren, ev, f, p, s, q, m;
        efp = 0; eren = 0; ev = 0; f = 0; p = 0; s = 0;
        chk("R2 port clock", int'(toh_clk), e % 2);
        if (e >= 2) begin
            m    = (e / 2 - 1) % FRAME;
            efp  = (m == 0) ? 1 : 0;
            eren = ((m % RS) < OH) ? 1 : 0;
        end
        chk("R3 frame pulse", int'(toh_fp), efp);
        chk("R4 read enable", int'(toh_ren), eren);
        if (e >= 3 && e % 2 == 1) begin
            f = (e - 3) / 2;
            if (f >= lead) begin
                p = (f - lead) % FRAME;
                s = p % RS;
                if (s < OH && s % 2 == 1) ev = 1;
            end
        end
        chk(ev != 0 ? "R5 octet strobe timing" : "R10 no octet outside overhead",
            int'(oct_valid), ev);
        if (ev != 0 && oct_valid) begin
            q = s / 2;
            chk("R6 octet data", int'(oct_data), nib_at(f - 1, seed) * 16 + nib_at(f, seed));
            chk(ovr_at(f, mode) != 0 ? "R8 override clears insert" : "R7 insert from high nibble",
                int'(oct_ins), (en_at(f - 1, mode) != 0 && ovr_at(f, mode) == 0) ? 1 : 0);
            chk("R9 row tag", int'(oct_row), p / RS);
            chk("R9 column tag", int'(oct_col), q / NS);
            chk("R9 sts tag", int'(oct_sts), q % NS);
        end
    endtask

    task automatic run_phase(int lead, int seed, int mode, int ncyc);
        int e;
        @(negedge clk);
        rst_n    = 1'b0;
        cfg_lead = LW'(lead);
        drive(7777, seed, mode);
        repeat (3) @(negedge clk);
        chk("R1 reset port clock", int'(toh_clk), 0);
        chk("R1 reset frame pulse", int'(toh_fp), 0);
        chk("R1 reset read enable", int'(toh_ren), 0);
        chk("R1 reset octet strobe", int'(oct_valid), 0);
        rst_n = 1'b1;
        e = 0;
        drive(1, seed, mode);
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            e++;
            @(negedge clk);
            check_cycle(e, lead, seed, mode);
            drive(e + 1, seed, mode);
        end
    endtask

    initial begin
        run_phase(0, 1, 0, 2 * FRAME * 3);
        run_phase(3, 4, 1, 2 * FRAME * 3);
        run_phase(7, 9, 2, 2 * FRAME * 3);
        run_phase(5, 2, 1, 2 * FRAME * 2 + 40);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule